// File: doc/BRIEF.md
# Mode-Based Packet Port Director

This block takes one forwarding decision per packet for a pair of external Ethernet ports. Each port has its own set of host-facing interfaces. The classifier upstream has already decided whether a packet matches a rule. The director combines that match flag with the ingress port and a software-set operating mode, and produces a destination bitmask. The mask can name the opposite external port, the ingress port's host interfaces, or nothing at all. An empty mask means the packet is dropped.

The mode selects one of three behaviours. In bypass, matching packets go to the host and all other packets cross to the other external port. In tap, every packet crosses to the other external port and matching packets are also copied to the host. In filter, matching packets go to the host and all other packets are discarded. Decisions leave through a registered valid/ready stage. Three running counters record delivered decisions: sent to the peer port, sent to the host, and dropped.

Top module: `pkt_port_director`

## Requirements
- R1: With mode code 0 (bypass), a matching packet gets only its own host bits: port A (in_port=0) uses mask bits 2 and 3, and port B (in_port=1) uses bits 4 and 5. A non-matching packet gets only the opposite external port bit: A goes to bit 1, and B goes to bit 0.
- R2: With mode code 1 (tap), every packet gets the opposite external port bit. A matching packet additionally gets its own host bits.
- R3: With mode code 2 (filter), a matching packet gets only its own host bits, and a non-matching packet is dropped.
- R4: Mode code 3 is reserved and produces exactly the same decisions as code 2.
- R5: The mode is sampled in the cycle a packet is accepted. A mode change made while that decision waits at the output does not alter the decision.
- R6: A dropped packet is presented with an all-zero mask and out_drop=1. Every other decision has out_drop=0.
- R7: in_ready is high whenever the output is empty or out_ready is high, so one decision can be accepted per cycle. While out_valid=1 and out_ready=0, out_dest and out_drop hold their values.
- R8: On each output handshake, cnt_peer increments if the mask holds an external port bit, cnt_host increments if it holds any host bit, and cnt_drop increments if out_drop=1. A tap match increments both cnt_peer and cnt_host. The new values are visible from the cycle after the handshake.
- R9: After reset, out_valid=0, in_ready=1 and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Operating mode: 0 bypass, 1 tap, 2 filter, 3 reserved (acts as filter) |
| in_valid | input | 1 | A packet decision request is present |
| in_ready | output | 1 | The block can accept a request this cycle |
| in_port | input | 1 | Ingress external port: 0 = A, 1 = B |
| in_match | input | 1 | Classifier rule-match flag |
| out_valid | output | 1 | A decision is presented |
| out_ready | input | 1 | Downstream takes the decision this cycle |
| out_dest | output | 2+2*HOSTS | Destination mask: bit 0 port A, bit 1 port B, then A's hosts, then B's hosts |
| out_drop | output | 1 | The presented decision is a drop |
| cnt_peer | output | CNT_W | Delivered decisions sent to the opposite external port |
| cnt_host | output | CNT_W | Delivered decisions sent to host interfaces |
| cnt_drop | output | CNT_W | Delivered drop decisions |

## Verification
Two functions can land in the same cycle. The first case is a tap-mode match, which must raise the peer counter and the host counter together. The scoreboard keeps its own three counters, updated from the expected decision at each handshake, and compares all three with the block's counters on every cycle. The second case is a mode change that coincides with a stall. A packet is accepted under bypass, out_ready is held low, and cfg_mode is switched to tap. The decision that finally drains must still be the bypass one, while the next packet is accepted under tap.

// File: rtl/pdir_pkg.sv
package pdir_pkg;

   typedef enum logic [1:0] {
      MODE_BYPASS = 2'd0,
      MODE_TAP    = 2'd1,
      MODE_FILTER = 2'd2,
      MODE_RSVD   = 2'd3
   } pdir_mode_e;

   typedef struct packed {
      logic to_peer;
      logic to_host;
      logic drop;
   } pdir_verdict_t;

   localparam int unsigned PDIR_N_EXT = 2;
   localparam int unsigned PDIR_N_CNT = 3;

endpackage

// File: rtl/pdir_policy.sv
module pdir_policy
   import pdir_pkg::*;
(
   input  logic [1:0]    mode,
   input  logic          match,
   output pdir_verdict_t verdict
);

   pdir_mode_e m;

   always_comb begin
      m = pdir_mode_e'(mode);
      verdict = '0;
      unique case (m)
         MODE_BYPASS: begin
            verdict.to_host = match;
            verdict.to_peer = ~match;
         end
         MODE_TAP: begin
            verdict.to_host = match;
            verdict.to_peer = 1'b1;
         end
         MODE_FILTER, MODE_RSVD: begin
            verdict.to_host = match;
            verdict.drop    = ~match;
         end
         default: verdict = '0;
      endcase
   end

endmodule

// File: rtl/pdir_mask.sv
module pdir_mask
   import pdir_pkg::*;
#(
   parameter int unsigned HOSTS  = 2,
   localparam int unsigned DEST_W = PDIR_N_EXT + PDIR_N_EXT * HOSTS
) (
   input  logic          port,
   input  pdir_verdict_t verdict,
   output logic [DEST_W-1:0] dest
);

   generate
      if (HOSTS < 1) begin : g_bad_hosts
         $error("pdir_mask: HOSTS must be at least 1");
      end
   endgenerate

   // external port bits: peer of the ingress port
   assign dest[0] = verdict.to_peer &  port;
   assign dest[1] = verdict.to_peer & ~port;

   // host groups, one per external port
   generate
      for (genvar g = 0; g < int'(PDIR_N_EXT); g++) begin : g_grp
         for (genvar h = 0; h < int'(HOSTS); h++) begin : g_host
            if (g == 0) begin : g_a
               assign dest[PDIR_N_EXT + g*HOSTS + h] = verdict.to_host & ~port;
            end else begin : g_b
               assign dest[PDIR_N_EXT + g*HOSTS + h] = verdict.to_host &  port;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pdir_stage.sv
module pdir_stage #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_valid,
   output logic         s_ready,
   input  logic [W-1:0] s_data,
   output logic         m_valid,
   input  logic         m_ready,
   output logic [W-1:0] m_data
);

   logic         vld_q;
   logic [W-1:0] dat_q;

   assign s_ready = ~vld_q | m_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (s_valid && s_ready) begin
         vld_q <= 1'b1;
         dat_q <= s_data;
      end else if (m_ready) begin
         vld_q <= 1'b0;
      end
   end

   assign m_valid = vld_q;
   assign m_data  = dat_q;

endmodule

// File: rtl/pdir_counters.sv
module pdir_counters #(
   parameter int unsigned N     = 3,
   parameter int unsigned CNT_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fire,
   input  logic [N-1:0]            hit,
   output logic [N-1:0][CNT_W-1:0] count
);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("pdir_counters: CNT_W must be at least 1");
      end
      for (genvar i = 0; i < int'(N); i++) begin : g_cnt
         logic [CNT_W-1:0] c_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             c_q <= '0;
            else if (fire && hit[i]) c_q <= c_q + CNT_W'(1);
         end
         assign count[i] = c_q;
      end
   endgenerate

endmodule

// File: rtl/pkt_port_director.sv
module pkt_port_director
   import pdir_pkg::*;
#(
   parameter int unsigned HOSTS  = 2,
   parameter int unsigned CNT_W  = 32,
   localparam int unsigned DEST_W = PDIR_N_EXT + PDIR_N_EXT * HOSTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_port,
   input  logic              in_match,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DEST_W-1:0] out_dest,
   output logic              out_drop,
   output logic [CNT_W-1:0]  cnt_peer,
   output logic [CNT_W-1:0]  cnt_host,
   output logic [CNT_W-1:0]  cnt_drop
);

   localparam int unsigned STG_W = DEST_W + 1;

   pdir_verdict_t verdict;
   logic [DEST_W-1:0] dest_d;
   logic [STG_W-1:0]  stg_q;
   logic [PDIR_N_CNT-1:0] hit;
   logic [PDIR_N_CNT-1:0][CNT_W-1:0] cnts;

   pdir_policy u_policy (
      .mode    (cfg_mode),
      .match   (in_match),
      .verdict (verdict)
   );

   pdir_mask #(.HOSTS(HOSTS)) u_mask (
      .port    (in_port),
      .verdict (verdict),
      .dest    (dest_d)
   );

   pdir_stage #(.W(STG_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (in_valid),
      .s_ready (in_ready),
      .s_data  ({verdict.drop, dest_d}),
      .m_valid (out_valid),
      .m_ready (out_ready),
      .m_data  (stg_q)
   );

   assign out_dest = stg_q[DEST_W-1:0];
   assign out_drop = stg_q[DEST_W];

   assign hit[0] = |out_dest[PDIR_N_EXT-1:0];
   assign hit[1] = |out_dest[DEST_W-1:PDIR_N_EXT];
   assign hit[2] = out_drop;

   pdir_counters #(.N(PDIR_N_CNT), .CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (out_valid & out_ready),
      .hit   (hit),
      .count (cnts)
   );

   assign cnt_peer = cnts[0];
   assign cnt_host = cnts[1];
   assign cnt_drop = cnts[2];

endmodule

// File: rtl/pdir_chk.sv
module pdir_chk #(
   parameter int unsigned HOSTS  = 2,
   parameter int unsigned CNT_W  = 32,
   localparam int unsigned DEST_W = 2 + 2 * HOSTS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DEST_W-1:0] out_dest,
   input logic              out_drop,
   input logic [CNT_W-1:0]  cnt_peer,
   input logic [CNT_W-1:0]  cnt_host,
   input logic [CNT_W-1:0]  cnt_drop
);

   logic [HOSTS-1:0] ha, hb;
   assign ha = out_dest[2 +: HOSTS];
   assign hb = out_dest[2+HOSTS +: HOSTS];

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_dest) && $stable(out_drop)) else $error("stall hold"); // R7
   AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid || out_ready) |-> in_ready) else $error("ready"); // R7
   AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid) else $error("accept"); // R7
   AST_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_drop |-> out_dest == '0) else $error("drop mask"); // R6
   AST_NODROP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_drop |-> out_dest != '0) else $error("empty non-drop"); // R6
   AST_ONE_PEER: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(out_dest[1:0]) <= 1) else $error("peer bits"); // R2
   AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !((|ha) && (|hb)) && ((&ha) == (|ha)) && ((&hb) == (|hb))) else $error("host group"); // R1
   AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_drop |=> cnt_drop == $past(cnt_drop) + CNT_W'(1)) else $error("drop cnt"); // R8
   AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_ready && out_drop) |=> $stable(cnt_drop)) else $error("drop cnt idle"); // R8
   AST_PEER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_ready) |=> $stable(cnt_peer) && $stable(cnt_host)) else $error("cnt idle"); // R8

endmodule

bind pkt_port_director pdir_chk #(.HOSTS(HOSTS), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_dest  (out_dest),
   .out_drop  (out_drop),
   .cnt_peer  (cnt_peer),
   .cnt_host  (cnt_host),
   .cnt_drop  (cnt_drop)
);

// File: tb/sim_pkt_port_director.sv
module sim_pkt_port_director;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic in_port = 1'b0;
   logic in_match = 1'b0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic [5:0] out_dest;
   logic out_drop;
   logic [CW-1:0] cnt_peer, cnt_host, cnt_drop;

   pkt_port_director #(.HOSTS(2), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .in_valid(in_valid), .in_ready(in_ready), .in_port(in_port), .in_match(in_match),
      .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest), .out_drop(out_drop),
      .cnt_peer(cnt_peer), .cnt_host(cnt_host), .cnt_drop(cnt_drop)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   int rdy_pat = 0;      // 0 always, 1 alternate, 2 held low, 3 pseudo-random
   logic [7:0] lfsr = 8'hA5;
   logic mon_on = 1'b0;

   logic [6:0] exp_q[$];  // {drop, mask}
   string      tag_q[$];
   logic [CW-1:0] m_peer = '0, m_host = '0, m_drop = '0;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [6:0] model(input logic [1:0] mode, input logic port, input logic match);
      logic [5:0] peer, host;
      peer = port ? 6'b000001 : 6'b000010;
      host = port ? 6'b110000 : 6'b001100;
      case (mode)
         2'd0:    return match ? {1'b0, host} : {1'b0, peer};
         2'd1:    return match ? {1'b0, host | peer} : {1'b0, peer};
         default: return match ? {1'b0, host} : {1'b1, 6'b0};
      endcase
   endfunction

   // driver: one packet, mode applied together with it
   task automatic send(input logic [1:0] mode, input logic port, input logic match, input string req);
      @(negedge clk);
      cfg_mode = mode; in_port = port; in_match = match; in_valid = 1'b1;
      forever begin
         #(CLK_PERIOD/4);
         if (rdy_pat == 0) check(in_ready === 1'b1, "R7 ready", in_ready, 1);
         if (in_ready) begin
            exp_q.push_back(model(mode, port, match));
            tag_q.push_back(req);
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      logic [6:0] e;
      string t;
      cycles++;
      if (mon_on) begin
         check(cnt_peer === m_peer, "R8 cnt_peer", cnt_peer, m_peer);
         check(cnt_host === m_host, "R8 cnt_host", cnt_host, m_host);
         check(cnt_drop === m_drop, "R8 cnt_drop", cnt_drop, m_drop);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         case (rdy_pat)
            0: out_ready = 1'b1;
            1: out_ready = cycles[0];
            2: out_ready = 1'b0;
            default: out_ready = lfsr[0];
         endcase
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected output", {out_drop, out_dest}, 0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({out_drop, out_dest} === e, t, {out_drop, out_dest}, e);
               if (|e[1:0]) m_peer = m_peer + 1;
               if (|e[5:2]) m_host = m_host + 1;
               if (e[6])    m_drop = m_drop + 1;
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #(CLK_PERIOD/4);
      // R9 reset state
      check(out_valid === 1'b0, "R9 out_valid", out_valid, 0);
      check(in_ready === 1'b1, "R9 in_ready", in_ready, 1);
      check({cnt_peer, cnt_host, cnt_drop} === '0, "R9 counters", cnt_peer | cnt_host | cnt_drop, 0);
      mon_on = 1'b1;

      // every mode/port/match combination, back to back, ready always high
      rdy_pat = 0;
      for (int m = 0; m < 4; m++)
         for (int p = 0; p < 2; p++)
            for (int k = 0; k < 2; k++)
               send(2'(m), 1'(p), 1'(k),
                    m == 0 ? "R1 bypass" : m == 1 ? "R2 tap" : m == 2 ? "R3/R6 filter" : "R4 reserved");

      // under backpressure patterns
      rdy_pat = 1;
      for (int i = 0; i < 16; i++) send(2'(i % 4), 1'(i / 4), 1'(i / 2), "R7 alternating ready");
      rdy_pat = 3;
      for (int i = 0; i < 24; i++) send(2'((i * 3) % 4), 1'(i), 1'(i / 3), "R7 random ready");
      rdy_pat = 0;
      repeat (4) @(negedge clk);

      // R5: mode change while the decision is stalled at the output
      rdy_pat = 2;
      repeat (2) @(negedge clk);
      send(2'd0, 1'b0, 1'b0, "R5 old mode kept");
      cfg_mode = 2'd1;
      repeat (3) @(negedge clk);
      #(CLK_PERIOD/4);
      check(out_valid === 1'b1 && out_dest === 6'b000010, "R5/R7 held decision", out_dest, 6'b000010);
      rdy_pat = 0;
      send(2'd1, 1'b0, 1'b1, "R5 new mode applies");
      send(2'd3, 1'b1, 1'b0, "R4 reserved drop");

      repeat (6) @(negedge clk);
      check(exp_q.size() == 0, "R7 all drained", exp_q.size(), 0);
      #(CLK_PERIOD/4);
      check(cnt_drop === m_drop && m_drop != 0, "R8 final drops", cnt_drop, m_drop);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule